// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Entry

This block keeps the coherence record for a single memory block in a shared-memory multiprocessor. It enforces the rule that the block has either one writer or any number of readers. Up to `NPTR` holders are recorded as explicit node-ID pointers in hardware. Requests arrive tagged with a node ID and are one of three kinds: read, write or eviction. The block answers with grants and sends invalidations to the current holders before it hands out write ownership.

When a reader arrives and every hardware pointer is already in use, the block accepts the reader anyway. It raises a one-cycle trap and sets a sticky overflow flag, so that a software handler can keep track of the extra holders. While that flag is set, every write also raises the trap, because the hardware cannot invalidate sharers that it never recorded. Software clears the flag with a pulse on `sw_clear`.

Top module: `dir_ptr_ctrl`

## Requirements
- R1: After reset, `dir_state` is 0 (uncached), `sharer_cnt` is 0, `ovf_flag`, `trap`, `grant_valid` and `inv_valid` are low, and `req_ready` is high.
- R2: An accepted read (`req_kind`=0) from a node not on the list, in state uncached (0) or shared (1), while a pointer is free: on the next cycle `grant_valid`=1, `grant_excl`=0, `grant_node` is the requester, `sharer_cnt` has risen by one, and `dir_state` is 1.
- R3: A read from a node already on the list is granted shared on the next cycle, and `sharer_cnt` does not change.
- R4: A read from a new node when all `NPTR` pointers are in use gives a shared grant. On the next cycle it raises `trap` for exactly one cycle and sets `ovf_flag`. `sharer_cnt` stays at `NPTR`.
- R5: `ovf_flag` stays set until a `sw_clear` pulse, and clears on the cycle after that pulse.
- R6: An accepted write (`req_kind`=1) that has other holders moves the block to state 3 (waiting) and drops `req_ready`. While waiting, it issues one `inv_valid` per cycle, to each recorded holder other than the requester, in ascending pointer-slot order.
- R7: Exclusive ownership is granted only on the cycle after the last outstanding `ack_valid`. The grant has `grant_excl`=1, and afterwards `dir_state` is 2 (exclusive) and `sharer_cnt` is 1.
- R8: An accepted write while `ovf_flag` is set raises `trap` on the next cycle.
- R9: A write from a node that is the only holder, or a write to an uncached block, is granted exclusive on the next cycle with no invalidation.
- R10: In state exclusive, a read from the owner is re-granted exclusive. A read from another node first invalidates the owner, then after its acknowledgement gives a shared grant: `dir_state` becomes 1 and `sharer_cnt` becomes 1.
- R11: An eviction (`req_kind`=2) removes the matching pointer. The block returns to uncached when the list empties and `ovf_flag` is clear. With `ovf_flag` set it remains shared.
- R12: A `sw_clear` pulse in state shared with an empty pointer list returns the block to uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_kind | input | 2 | 0 read, 1 write, 2 eviction, 3 no effect |
| req_node | input | NODE_W | Requesting node ID |
| ack_valid | input | 1 | One invalidation acknowledgement |
| sw_clear | input | 1 | Software clears the overflow flag |
| req_ready | output | 1 | Low while waiting for acknowledgements |
| grant_valid | output | 1 | One-cycle grant response |
| grant_excl | output | 1 | Grant is exclusive (1) or shared (0) |
| grant_node | output | NODE_W | Node receiving the grant |
| inv_valid | output | 1 | Invalidation request this cycle |
| inv_node | output | NODE_W | Node to invalidate |
| trap | output | 1 | One-cycle software trap |
| ovf_flag | output | 1 | Sharer list extended in software |
| dir_state | output | 2 | 0 uncached, 1 shared, 2 exclusive, 3 waiting |
| sharer_cnt | output | $clog2(NPTR+1) | Pointers held in hardware |

## Verification
The assertions assume that `ack_valid` comes only while invalidations are outstanding, at most one per cycle and never more than were sent. They also assume that `sw_clear` does not coincide with an accepted request. The bench keeps to this: each test counts the invalidations it has seen, returns exactly that many acknowledgements one cycle apart, and pulses `sw_clear` only on idle cycles. Requests are held for a single cycle, and only while `req_ready` is high.

// File: rtl/dir_ptr_ctrl.sv
module dir_ptr_ctrl #(
  parameter int NODE_W = 4,
  parameter int NPTR   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_kind,
  input  logic [NODE_W-1:0]           req_node,
  input  logic                        ack_valid,
  input  logic                        sw_clear,
  output logic                        req_ready,
  output logic                        grant_valid,
  output logic                        grant_excl,
  output logic [NODE_W-1:0]           grant_node,
  output logic                        inv_valid,
  output logic [NODE_W-1:0]           inv_node,
  output logic                        trap,
  output logic                        ovf_flag,
  output logic [1:0]                  dir_state,
  output logic [$clog2(NPTR+1)-1:0]   sharer_cnt
);
  localparam int CW = $clog2(NPTR + 1);
  localparam int IW = (NPTR > 1) ? $clog2(NPTR) : 1;
  localparam logic [1:0] ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2, ST_WAIT = 2'd3;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EV = 2'd2;

  logic [1:0]        state;
  logic [NODE_W-1:0] ptr [NPTR];
  logic [NPTR-1:0]   vld, hit, others;
  logic [CW-1:0]     pend, pend_nx, cnt;
  logic [NODE_W-1:0] owner_q;
  logic              wr_q, ovf;
  logic [IW-1:0]     free_idx, inv_idx;
  logic              has_free, has_inv, present, accept;

  always_comb begin
    free_idx = '0; inv_idx = '0; has_free = 1'b0; has_inv = 1'b0; cnt = '0;
    for (int i = NPTR - 1; i >= 0; i--) begin
      hit[i] = vld[i] && (ptr[i] == req_node);
      if (!vld[i]) begin free_idx = IW'(i); has_free = 1'b1; end
      if (vld[i])  begin inv_idx  = IW'(i); has_inv  = 1'b1; end
      cnt = cnt + CW'(vld[i]);
    end
  end

  assign present    = |hit;
  assign others     = vld & ~hit;
  assign accept     = req_valid && (state != ST_WAIT);
  assign pend_nx    = pend + CW'(has_inv) - CW'(ack_valid);
  assign req_ready  = (state != ST_WAIT);
  assign inv_valid  = (state == ST_WAIT) && has_inv;
  assign inv_node   = ptr[inv_idx];
  assign ovf_flag   = ovf;
  assign dir_state  = state;
  assign sharer_cnt = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_UNC; vld <= '0; ovf <= 1'b0; pend <= '0;
      owner_q <= '0; wr_q <= 1'b0; trap <= 1'b0;
      grant_valid <= 1'b0; grant_excl <= 1'b0; grant_node <= '0;
      for (int i = 0; i < NPTR; i++) ptr[i] <= '0;
    end else begin
      grant_valid <= 1'b0;
      trap <= 1'b0;
      if (sw_clear) begin
        ovf <= 1'b0;
        if (state == ST_SHR && vld == '0 && !accept) state <= ST_UNC;
      end
      if (state == ST_WAIT) begin
        pend <= pend_nx;
        if (has_inv) vld[inv_idx] <= 1'b0;
        if (!has_inv && pend_nx == '0) begin
          vld <= NPTR'(1);
          ptr[0] <= owner_q;
          grant_valid <= 1'b1; grant_excl <= wr_q; grant_node <= owner_q;
          state <= wr_q ? ST_EXC : ST_SHR;
        end
      end else if (accept) begin
        grant_node <= req_node;
        case (req_kind)
          K_RD: begin
            if (state == ST_EXC && !present) begin
              owner_q <= req_node; wr_q <= 1'b0; state <= ST_WAIT;
            end else if (state == ST_EXC) begin
              grant_valid <= 1'b1; grant_excl <= 1'b1;
            end else begin
              grant_valid <= 1'b1; grant_excl <= 1'b0; state <= ST_SHR;
              if (!present && has_free) begin
                vld[free_idx] <= 1'b1; ptr[free_idx] <= req_node;
              end else if (!present) begin
                ovf <= 1'b1; trap <= 1'b1;
              end
            end
          end
          K_WR: begin
            if (ovf) trap <= 1'b1;
            if (others == '0) begin
              vld <= NPTR'(1); ptr[0] <= req_node;
              grant_valid <= 1'b1; grant_excl <= 1'b1; state <= ST_EXC;
            end else begin
              vld <= others; owner_q <= req_node; wr_q <= 1'b1; state <= ST_WAIT;
            end
          end
          K_EV: begin
            vld <= others;
            if (others == '0) state <= ovf ? ST_SHR : ST_UNC;
          end
          default: ;
        endcase
      end
    end
  end

  assert_excl_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_EXC |-> cnt == CW'(1));
  assert_ack_expected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> state == ST_WAIT && pend != '0);
  assert_no_early_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && pend != '0 && !ack_valid) |=> !grant_valid);
  assert_inv_not_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_node != owner_q);
  assert_no_dup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == K_RD && present && state != ST_EXC) |=> cnt == $past(cnt));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_clear) |=> ovf);
  assert_trap_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == K_WR && ovf) |=> trap);
  assert_full_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == K_RD && !present && !has_free && state != ST_EXC) |=> trap && ovf);
endmodule

// File: tb/sim_dir_ptr_ctrl.sv
module sim_dir_ptr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ack_valid = 1'b0, sw_clear = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [3:0] req_node = 4'd0;
  logic req_ready, grant_valid, grant_excl, inv_valid, trap, ovf_flag;
  logic [3:0] grant_node, inv_node;
  logic [1:0] dir_state;
  logic [2:0] sharer_cnt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dir_ptr_ctrl #(.NODE_W(4), .NPTR(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_node(req_node), .ack_valid(ack_valid), .sw_clear(sw_clear),
    .req_ready(req_ready), .grant_valid(grant_valid), .grant_excl(grant_excl),
    .grant_node(grant_node), .inv_valid(inv_valid), .inv_node(inv_node),
    .trap(trap), .ovf_flag(ovf_flag), .dir_state(dir_state), .sharer_cnt(sharer_cnt));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] n);
    @(negedge clk); req_valid = 1'b1; req_kind = k; req_node = n;
    @(posedge clk); #1; req_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ack_valid = 1'b1;
    @(posedge clk); #1; ack_valid = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); sw_clear = 1'b1;
    @(posedge clk); #1; sw_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", dir_state, 0); chk("R1 cnt", sharer_cnt, 0);
    chk("R1 ovf", ovf_flag, 0); chk("R1 trap", trap, 0);
    chk("R1 grant", grant_valid, 0); chk("R1 inv", inv_valid, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_reads();
    send(2'd0, 4'd1);
    chk("R2 grant", grant_valid, 1); chk("R2 excl", grant_excl, 0);
    chk("R2 node", grant_node, 1); chk("R2 cnt", sharer_cnt, 1); chk("R2 state", dir_state, 1);
    send(2'd0, 4'd1);
    chk("R3 grant", grant_valid, 1); chk("R3 cnt", sharer_cnt, 1);
    send(2'd0, 4'd2); send(2'd0, 4'd3); send(2'd0, 4'd4);
    chk("R2 cnt4", sharer_cnt, 4);
  endtask

  task automatic t_overflow(input logic [3:0] n);
    send(2'd0, n);
    chk("R4 grant", grant_valid, 1); chk("R4 excl", grant_excl, 0);
    chk("R4 trap", trap, 1); chk("R4 ovf", ovf_flag, 1); chk("R4 cnt", sharer_cnt, 4);
    @(posedge clk); #1;
    chk("R4 trap one cycle", trap, 0); chk("R5 ovf held", ovf_flag, 1);
  endtask

  task automatic t_write_inv();
    send(2'd1, 4'd2);
    chk("R8 trap", trap, 1); chk("R6 ready", req_ready, 0); chk("R6 state", dir_state, 3);
    chk("R6 inv0", inv_valid, 1); chk("R6 node0", inv_node, 1);
    @(posedge clk); #1; chk("R6 node1", inv_node, 3);
    @(posedge clk); #1; chk("R6 node2", inv_node, 4);
    @(posedge clk); #1; chk("R6 done", inv_valid, 0); chk("R7 no grant", grant_valid, 0);
    ack(); chk("R7 wait1", grant_valid, 0);
    ack(); chk("R7 wait2", grant_valid, 0);
    ack();
    chk("R7 grant", grant_valid, 1); chk("R7 excl", grant_excl, 1);
    chk("R7 node", grant_node, 2); chk("R7 state", dir_state, 2); chk("R7 cnt", sharer_cnt, 1);
    chk("R5 ovf still", ovf_flag, 1);
    clr(); chk("R5 cleared", ovf_flag, 0); chk("R5 state", dir_state, 2);
  endtask

  task automatic t_excl_read();
    send(2'd0, 4'd2);
    chk("R10 owner grant", grant_valid, 1); chk("R10 owner excl", grant_excl, 1);
    send(2'd0, 4'd7);
    chk("R10 inv", inv_valid, 1); chk("R10 inv node", inv_node, 2); chk("R10 ready", req_ready, 0);
    @(posedge clk); #1; chk("R10 no grant", grant_valid, 0);
    ack();
    chk("R10 grant", grant_valid, 1); chk("R10 shared", grant_excl, 0);
    chk("R10 node", grant_node, 7); chk("R10 state", dir_state, 1); chk("R10 cnt", sharer_cnt, 1);
  endtask

  task automatic t_sole_write();
    send(2'd1, 4'd7);
    chk("R9 grant", grant_valid, 1); chk("R9 excl", grant_excl, 1);
    chk("R9 no inv", inv_valid, 0); chk("R9 state", dir_state, 2); chk("R9 trap", trap, 0);
    send(2'd2, 4'd7);
    chk("R11 uncached", dir_state, 0); chk("R11 cnt", sharer_cnt, 0);
  endtask

  task automatic t_evict_ovf();
    for (int i = 1; i <= 4; i++) send(2'd0, 4'(i));
    t_overflow(4'd5);
    send(2'd2, 4'd3); chk("R11 cnt3", sharer_cnt, 3); chk("R11 shr", dir_state, 1);
    send(2'd2, 4'd1); send(2'd2, 4'd2); send(2'd2, 4'd4);
    chk("R11 cnt0", sharer_cnt, 0); chk("R11 stays shared", dir_state, 1);
    clr(); chk("R12 uncached", dir_state, 0); chk("R12 ovf", ovf_flag, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_reads();
    t_overflow(4'd5);
    t_write_inv();
    t_excl_read();
    t_sole_write();
    t_evict_ovf();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule